// File: doc/BRIEF.md
# 256-bit Vector Data-Movement Unit

This block performs the data-rearranging operations of a 256-bit SIMD datapath. It takes two 256-bit sources, a 128-bit insert operand and an 8-bit immediate, and returns one registered 256-bit result. The operations are:

- **Broadcast:** replicate a scalar of 32, 64 or 128 bits across the whole vector.
- **Insert:** overwrite one 128-bit half while the other half keeps its value.
- **Extract:** pull out one 128-bit half.
- **In-lane shuffle:** rearrange elements only inside each 128-bit lane.
- **Cross-lane select:** build the result from any of the four 128-bit chunks of both sources, with an optional zero per half.

A narrow flag selects 128-bit operation. In that mode only the low half is produced and the upper 128 bits are cleared. The result appears one clock after a valid input. The result register keeps its value until the next valid input arrives.

Top module: `vec_shuffle_unit`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and `result` is all zeros.
- R2: Broadcast opcodes replicate the low bits of `src_a` into every element position:
  - opcode 0 copies `src_a[31:0]` into all eight 32-bit elements;
  - opcode 1 copies `src_a[63:0]` into all four 64-bit elements;
  - opcode 2 copies `src_a[127:0]` into both halves.
- R3: Opcode 3 (insert) returns `src_a` with one half replaced by `ins_val`:
  - `imm[0]`=0 replaces bits 127:0;
  - `imm[0]`=1 replaces bits 255:128;
  - the other half is taken unchanged from `src_a`.
- R4: Opcode 4 (extract) returns the half of `src_a` chosen by `imm[0]` in bits 127:0 (0 selects the low half, 1 the high half). Bits 255:128 are zero.
- R5: Opcode 5 (32-bit in-lane shuffle) sets destination element j of lane L (j=0..3, L=0..1) to source element j' of lane L of `src_a`, where j' is `imm[2j+1:2j]`. Both lanes use the same four indices.
- R6: Opcode 6 (64-bit in-lane shuffle) sets destination 64-bit element k (k=0..3) to element `imm[k]` of the 128-bit lane that holds element k of `src_a`.
- R7: Opcode 7 (cross-lane select) numbers the chunks 0 = `src_a` low, 1 = `src_a` high, 2 = `src_b` low, 3 = `src_b` high.
  - The low half of the result is chunk `imm[1:0]`, or zero when `imm[3]` is 1.
  - The high half is chunk `imm[5:4]`, or zero when `imm[7]` is 1.
- R8: When `narrow` is 1, bits 255:128 of the result are zero for every opcode. Bits 127:0 are as in full-width mode.
- R9: A cycle with `in_valid` high makes `out_valid` high in the next cycle, with `result` updated in that same cycle.
- R10: A cycle with `in_valid` low makes `out_valid` low in the next cycle and leaves `result` unchanged.
- R11: Opcodes 8 to 15 produce an all-zero result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation request this cycle |
| op | input | 4 | Operation code |
| narrow | input | 1 | 128-bit operation mode |
| src_a | input | 256 | First source vector |
| src_b | input | 256 | Second source vector |
| ins_val | input | 128 | Insert operand |
| imm | input | 8 | Immediate control |
| out_valid | output | 1 | Result valid |
| result | output | 256 | Registered result |

## Verification
The bench runs every index pattern through the in-lane shuffles, including indices that pick the same element several times. A design that let an element cross the lane boundary would put wrong data in the upper lane under those patterns.

For the cross-lane select, the bench covers all chunk choices together with the two zero bits, so a mis-numbered chunk or an ignored zero bit shows up in the result.

Insert is driven with both half-select values to catch a design that clobbers the kept half. Narrow mode is applied to every opcode to catch stray data left in the upper bits. Idle cycles are placed between requests to catch a result register that reloads without `in_valid`.

// File: rtl/vec_shuffle_unit.sv
module vec_shuffle_unit #(
  parameter int W = 256,
  parameter int E32 = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [3:0]   op,
  input  logic         narrow,
  input  logic [W-1:0] src_a,
  input  logic [W-1:0] src_b,
  input  logic [W/2-1:0] ins_val,
  input  logic [7:0]   imm,
  output logic         out_valid,
  output logic [W-1:0] result
);
  localparam int H = W / 2;
  localparam int N32 = W / E32;
  localparam int PER_LANE32 = H / E32;
  localparam int E64 = 2 * E32;
  localparam int N64 = W / E64;

  logic [W-1:0] bc32, bc64, bc128, ins_r, ext_r, p32, p64, xl, nxt;
  logic [H-1:0] chunk [4];

  assign chunk[0] = src_a[H-1:0];
  assign chunk[1] = src_a[W-1:H];
  assign chunk[2] = src_b[H-1:0];
  assign chunk[3] = src_b[W-1:H];

  genvar g;
  generate
    for (g = 0; g < N32; g++) begin : g_e32
      localparam int LANE = g / PER_LANE32;
      localparam int POS = g % PER_LANE32;
      logic [1:0] sel;
      assign sel = imm[2*POS +: 2];
      assign bc32[g*E32 +: E32] = src_a[E32-1:0];
      assign p32[g*E32 +: E32] = src_a[LANE*H + int'(sel)*E32 +: E32];
    end
    for (g = 0; g < N64; g++) begin : g_e64
      localparam int LANE = g / 2;
      assign bc64[g*E64 +: E64] = src_a[E64-1:0];
      assign p64[g*E64 +: E64] = src_a[LANE*H + int'(imm[g])*E64 +: E64];
    end
  endgenerate

  assign bc128 = {src_a[H-1:0], src_a[H-1:0]};
  assign ins_r = imm[0] ? {ins_val, src_a[H-1:0]} : {src_a[W-1:H], ins_val};
  assign ext_r = {{H{1'b0}}, imm[0] ? src_a[W-1:H] : src_a[H-1:0]};
  assign xl = {imm[7] ? {H{1'b0}} : chunk[imm[5:4]],
               imm[3] ? {H{1'b0}} : chunk[imm[1:0]]};

  always_comb begin
    case (op)
      4'd0: nxt = bc32;
      4'd1: nxt = bc64;
      4'd2: nxt = bc128;
      4'd3: nxt = ins_r;
      4'd4: nxt = ext_r;
      4'd5: nxt = p32;
      4'd6: nxt = p64;
      4'd7: nxt = xl;
      default: nxt = '0;
    endcase
    if (narrow) nxt[W-1:H] = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= nxt;
    end
  end
endmodule

module vec_shuffle_chk #(
  parameter int W = 256
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [3:0]   op,
  input logic         narrow,
  input logic [W-1:0] src_a,
  input logic [W-1:0] src_b,
  input logic [W/2-1:0] ins_val,
  input logic [7:0]   imm,
  input logic         out_valid,
  input logic [W-1:0] result
);
  localparam int H = W / 2;

  p_valid_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_idle_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result));
  p_narrow_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && narrow) |=> result[W-1:H] == '0);
  p_insert_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 4'd3 && !narrow && imm[0]) |=> result[H-1:0] == $past(src_a[H-1:0]));
  p_extract_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 4'd4) |=> result[W-1:H] == '0);
  p_xlane_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 4'd7 && imm[3]) |=> result[H-1:0] == '0);
  p_bad_op_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op[3]) |=> result == '0);
endmodule

bind vec_shuffle_unit vec_shuffle_chk #(.W(W)) u_chk (.*);

// File: tb/tb_vec_shuffle_unit.sv
module tb_vec_shuffle_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [3:0] op = '0;
  logic narrow = 1'b0;
  logic [255:0] src_a = '0, src_b = '0;
  logic [127:0] ins_val = '0;
  logic [7:0] imm = '0;
  logic out_valid;
  logic [255:0] result;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  vec_shuffle_unit dut (.*);

  logic exp_valid = 1'b0;
  logic [255:0] exp_res = '0;
  string exp_tag = "R1";

  function automatic logic [255:0] model(input logic [3:0] o, input logic nw,
      input logic [255:0] a, input logic [255:0] b, input logic [127:0] iv,
      input logic [7:0] im);
    logic [255:0] r;
    logic [127:0] ch [4];
    r = '0;
    ch[0] = a[127:0]; ch[1] = a[255:128]; ch[2] = b[127:0]; ch[3] = b[255:128];
    case (o)
      0: for (int i = 0; i < 8; i++) r[i*32 +: 32] = a[31:0];
      1: for (int i = 0; i < 4; i++) r[i*64 +: 64] = a[63:0];
      2: r = {a[127:0], a[127:0]};
      3: begin r = a; if (im[0]) r[255:128] = iv; else r[127:0] = iv; end
      4: r[127:0] = im[0] ? a[255:128] : a[127:0];
      5: for (int i = 0; i < 8; i++) begin
           int lane, src;
           lane = i / 4;
           src = int'(im[(i%4)*2 +: 2]);
           r[i*32 +: 32] = a[lane*128 + src*32 +: 32];
         end
      6: for (int i = 0; i < 4; i++) begin
           int lane;
           lane = i / 2;
           r[i*64 +: 64] = a[lane*128 + int'(im[i])*64 +: 64];
         end
      7: begin
           r[127:0] = im[3] ? 128'd0 : ch[im[1:0]];
           r[255:128] = im[7] ? 128'd0 : ch[im[5:4]];
         end
      default: r = '0;
    endcase
    if (nw) r[255:128] = '0;
    return r;
  endfunction

  function automatic string tag_of(input logic [3:0] o, input logic nw);
    if (nw) return "R8";
    case (o)
      0, 1, 2: return "R2";
      3: return "R3";
      4: return "R4";
      5: return "R5";
      6: return "R6";
      7: return "R7";
      default: return "R11";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      exp_valid <= 1'b0;
      exp_res <= '0;
      exp_tag <= "R1";
    end else begin
      exp_valid <= in_valid;
      if (in_valid) begin
        exp_res <= model(op, narrow, src_a, src_b, ins_val, imm);
        exp_tag <= tag_of(op, narrow);
      end else begin
        exp_tag <= "R10";
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (out_valid !== exp_valid) begin
        errors++;
        $display("FAIL %s R9 valid: actual=%0b expected=%0b", exp_tag, out_valid, exp_valid);
      end else if (result !== exp_res) begin
        errors++;
        $display("FAIL %s result: actual=%h expected=%h", exp_tag, result, exp_res);
      end
    end
  end

  task automatic issue(input logic [3:0] o, input logic nw, input logic [7:0] im);
    @(negedge clk);
    in_valid = 1'b1; op = o; narrow = nw; imm = im;
    src_a = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
    src_b = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
    ins_val = {$urandom, $urandom, $urandom, $urandom};
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      src_a = ~src_a; imm = ~imm; op = op + 4'd1;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int o = 0; o < 8; o++)
      for (int k = 0; k < 4; k++) begin
        issue(4'(o), 1'b0, 8'($urandom));
        idle(k % 2);
      end
    for (int m = 0; m < 256; m++) issue(4'd5, 1'b0, 8'(m));
    for (int m = 0; m < 16; m++) issue(4'd6, 1'b0, 8'(m));
    for (int m = 0; m < 256; m++) issue(4'd7, 1'b0, 8'(m));
    for (int h = 0; h < 2; h++) begin
      issue(4'd3, 1'b0, 8'(h));
      issue(4'd4, 1'b0, 8'(h));
    end
    for (int o = 0; o < 16; o++) begin
      issue(4'(o), 1'b1, 8'($urandom));
      issue(4'(o), 1'b0, 8'($urandom));
    end
    idle(4);
    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule